// File: doc/BRIEF.md
# Slave PCM Codec Serial Port

This block is a synchronous serial port for voice samples that works only as a slave. An external master supplies the serial clock and the frame-sync input. In each frame the port moves one channel word in each direction. It receives the word on the serial data input and sends the transmit word on the serial data output, most significant bit first. The channel word is either 8 or 16 bits wide.

All of the port's logic runs on the system clock. The serial clock, frame sync and data input are synchronised and their edges are detected. With double-rate selected, two input-clock cycles make up one bit period. The port also drives a frame-sync output. Its high time depends on the selected frame style: one bit for the short form, the whole channel for the long form. The serial data timing is the same for both forms.

On the parallel side, a one-word transmit holding register takes words through a valid/ready handshake. Received words leave with a one-cycle valid strobe. Configuration is sampled at the start of each frame.

Top module: `pcm_slave_port`

## Requirements
- R1: With `cfg_wide` = 1 a frame carries 16 bits, and with `cfg_wide` = 0 it carries 8. The transmit word goes out most significant bit first. In 8-bit frames only `tx_data[7:0]` is sent.
- R2: After the last received bit is sampled, `rx_valid` is high for exactly one clock. In that cycle `rx_data` holds the received bits with the first bit in the most significant position of the word. In 8-bit frames the word sits in `rx_data[7:0]` and bits 15:8 are zero.
- R3: A frame starts only when `fsync_in` is high at a rising edge of `sclk_in` and is still high at the next falling edge. A pulse that drops before that falling edge starts no frame: no data is driven, no word is received and the held transmit word stays held.
- R4: With `cfg_dbl` = 1 each bit spans two `sclk_in` cycles. The first rising edge after the frame start opens bit 0. Data out changes on the first rising edge of each pair, and data in is sampled on the second rising edge.
- R5: With `cfg_dbl` = 0 data out changes on each rising edge of `sclk_in` and data in is sampled on each falling edge. The first bit begins at the first rising edge after the frame start. `sdout_oe` is high only for the bits of the channel slot, and `sdout` is low whenever `sdout_oe` is low.
- R6: `fsync_out` rises with the first bit. With `cfg_long` = 0 it stays high for one bit period. With `cfg_long` = 1 it stays high for the full channel width.
- R7: `tx_ready` is high while the holding register is empty. A word accepted with `tx_valid` and `tx_ready` both high makes `tx_ready` low until a frame start loads that word.
- R8: If the holding register is empty at a frame start, the frame sends all zeros and `underrun` is set. `underrun` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1: 16-bit channel, 0: 8-bit channel |
| cfg_long | input | 1 | 1: long frame-sync output, 0: short |
| cfg_dbl | input | 1 | 1: two input-clock cycles per bit |
| sclk_in | input | 1 | Serial clock from the master |
| fsync_in | input | 1 | Frame sync from the master |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Output enable for sdout during the slot |
| fsync_out | output | 1 | Frame-sync output |
| tx_data | input | 16 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 16 | Received word |
| rx_valid | output | 1 | One-clock strobe for rx_data |
| underrun | output | 1 | Sticky: a frame started with no transmit word |

## Verification
The assertions assume that the serial clock is much slower than the system clock. Each half period of `sclk_in` must last longer than the synchroniser plus edge-detect delay, so rising and falling events never fall in the same clock cycle. They also assume that the master changes `fsync_in` and `sdin` only together with `sclk_in`, and that configuration is stable around a frame start. The stimulus holds every half period at ten system clocks. It changes the master signals at the same falling system-clock edge as the serial clock, and it sets the configuration a full input-clock cycle before each frame sync.

// File: rtl/pcm_slave_pkg.sv
package pcm_slave_pkg;
  localparam int WIDE_BITS   = 16;
  localparam int NARROW_BITS = 8;
  localparam int CNT_W       = $clog2(WIDE_BITS + 1);

  // number of bits in one channel slot
  function automatic logic [CNT_W-1:0] word_bits(input logic wide);
    return wide ? CNT_W'(WIDE_BITS) : CNT_W'(NARROW_BITS);
  endfunction

  // place the word so that its first bit sits at the shifter MSB
  function automatic logic [WIDE_BITS-1:0] align_tx(input logic [WIDE_BITS-1:0] d,
                                                    input logic wide);
    return wide ? d : {d[NARROW_BITS-1:0], {(WIDE_BITS-NARROW_BITS){1'b0}}};
  endfunction

  // keep only the bits of the active slot width
  function automatic logic [WIDE_BITS-1:0] trim_rx(input logic [WIDE_BITS-1:0] d,
                                                   input logic wide);
    return wide ? d : {{(WIDE_BITS-NARROW_BITS){1'b0}}, d[NARROW_BITS-1:0]};
  endfunction
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic dbl,
  input  logic realign,
  output logic clk_rise,
  output logic clk_fall,
  output logic bit_rise,
  output logic bit_fall
);
  logic prev_q;
  logic phase_q;

  assign clk_rise = sclk_s & ~prev_q;
  assign clk_fall = ~sclk_s & prev_q;

  // halved clock: even input rises open a bit, odd ones close it
  assign bit_rise = dbl ? (clk_rise & ~phase_q) : clk_rise;
  assign bit_fall = dbl ? (clk_rise &  phase_q) : clk_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      prev_q <= sclk_s;
      if (realign)              phase_q <= 1'b0;
      else if (dbl && clk_rise) phase_q <= ~phase_q;
    end
endmodule

// File: rtl/pcm_fs_qual.sv
module pcm_fs_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_s,
  input  logic clk_rise,
  input  logic clk_fall,
  output logic frame_start
);
  logic armed_q;
  logic seen_q;

  // high at a rise and still high at the following fall
  assign frame_start = clk_fall & armed_q & fs_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      if (clk_rise)         armed_q <= fs_s & ~seen_q;
      else if (frame_start) armed_q <= 1'b0;
      if (frame_start)              seen_q <= 1'b1;
      else if (clk_rise && !fs_s)   seen_q <= 1'b0;
    end
endmodule

// File: rtl/pcm_slave_port.sv
module pcm_slave_port
  import pcm_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wide,
  input  logic                 cfg_long,
  input  logic                 cfg_dbl,
  input  logic                 sclk_in,
  input  logic                 fsync_in,
  input  logic                 sdin,
  output logic                 sdout,
  output logic                 sdout_oe,
  output logic                 fsync_out,
  input  logic [WIDE_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [WIDE_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 underrun
);
  logic [2:0] pins_s;
  logic sclk_s, fs_s, sdin_s;
  logic clk_rise, clk_fall, bit_rise, bit_fall, frame_start;
  logic active, started, first, wide_q, long_q, dbl_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] last_idx;
  logic [WIDE_BITS-1:0] tx_sh, rx_sh, rx_next, hold_data, rx_data_q;
  logic hold_full, underrun_q, rx_valid_q, sdout_q, oe_q, fso_q;
  logic last_bit, take_bit, accept;

  pcm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_in, fsync_in, sdin}), .q(pins_s)
  );
  assign {sclk_s, fs_s, sdin_s} = pins_s;

  pcm_bit_timer timer_i (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .dbl(dbl_q),
    .realign(frame_start), .clk_rise(clk_rise), .clk_fall(clk_fall),
    .bit_rise(bit_rise), .bit_fall(bit_fall)
  );

  pcm_fs_qual fsq_i (
    .clk(clk), .rst_n(rst_n), .fs_s(fs_s), .clk_rise(clk_rise),
    .clk_fall(clk_fall), .frame_start(frame_start)
  );

  assign last_idx = word_bits(wide_q) - CNT_W'(1);
  assign take_bit = bit_fall & active & started;
  assign last_bit = take_bit & (bit_cnt == last_idx);
  assign rx_next  = {rx_sh[WIDE_BITS-2:0], sdin_s};
  assign accept   = tx_valid & ~hold_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; started <= 1'b0; first <= 1'b0;
      wide_q <= 1'b0; long_q <= 1'b0; dbl_q <= 1'b0;
      bit_cnt <= '0; tx_sh <= '0; rx_sh <= '0; rx_data_q <= '0;
      hold_data <= '0; hold_full <= 1'b0; underrun_q <= 1'b0;
      rx_valid_q <= 1'b0; sdout_q <= 1'b0; oe_q <= 1'b0; fso_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      // transmit side: advance on the bit's rising event
      if (bit_rise) begin
        if (active) begin
          sdout_q <= tx_sh[WIDE_BITS-1];
          tx_sh   <= {tx_sh[WIDE_BITS-2:0], 1'b0};
          oe_q    <= 1'b1;
          fso_q   <= long_q | first;
          started <= 1'b1;
          first   <= 1'b0;
        end else begin
          sdout_q <= 1'b0;
          oe_q    <= 1'b0;
          fso_q   <= 1'b0;
        end
      end
      // receive side: sample on the bit's falling event
      if (take_bit) begin
        rx_sh <= rx_next;
        if (last_bit) begin
          rx_data_q  <= trim_rx(rx_next, wide_q);
          rx_valid_q <= 1'b1;
          active     <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
      if (frame_start) begin
        active  <= 1'b1;
        started <= 1'b0;
        first   <= 1'b1;
        bit_cnt <= '0;
        wide_q  <= cfg_wide;
        long_q  <= cfg_long;
        dbl_q   <= cfg_dbl;
        if (hold_full) begin
          tx_sh     <= align_tx(hold_data, cfg_wide);
          hold_full <= 1'b0;
        end else begin
          tx_sh      <= '0;
          underrun_q <= 1'b1;
        end
      end
      if (accept) begin
        hold_data <= tx_data;
        hold_full <= 1'b1;
      end
    end

  assign sdout     = sdout_q;
  assign sdout_oe  = oe_q;
  assign fsync_out = fso_q;
  assign tx_ready  = ~hold_full;
  assign rx_data   = rx_data_q;
  assign rx_valid  = rx_valid_q;
  assign underrun  = underrun_q;
endmodule

// File: rtl/pcm_slave_port_chk.sv
module pcm_slave_port_chk
  import pcm_slave_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bit_rise,
  input logic             bit_fall,
  input logic             frame_start,
  input logic             rx_valid,
  input logic             sdout,
  input logic             sdout_oe,
  input logic             fsync_out,
  input logic             underrun,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [CNT_W-1:0] bit_cnt
);
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(WIDE_BITS));

  // R2
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3
  start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !bit_rise);

  // R4
  bit_edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_rise && bit_fall));

  // R5
  oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdout_oe != $past(sdout_oe)) |-> $past(bit_rise));

  // R5
  sdout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdout_oe |-> !sdout);

  // R6
  fso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_out != $past(fsync_out)) |-> $past(bit_rise));

  // R7
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
endmodule

bind pcm_slave_port pcm_slave_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
  .frame_start(frame_start), .rx_valid(rx_valid), .sdout(sdout),
  .sdout_oe(sdout_oe), .fsync_out(fsync_out), .underrun(underrun),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .bit_cnt(bit_cnt)
);

// File: tb/pcm_slave_port_tb.sv
`timescale 1ns/1ps
module pcm_slave_port_tb_top;
  localparam int HP       = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_long = 1'b0, cfg_dbl = 1'b0;
  logic sclk_in = 1'b0, fsync_in = 1'b0, sdin = 1'b0;
  logic sdout, sdout_oe, fsync_out, tx_ready, rx_valid, underrun;
  logic [15:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic [15:0] rx_data;

  int total = 0;
  int fails = 0;
  int rx_pulses = 0;
  logic [15:0] rx_last = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcm_slave_port dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_long(cfg_long),
    .cfg_dbl(cfg_dbl), .sclk_in(sclk_in), .fsync_in(fsync_in), .sdin(sdin),
    .sdout(sdout), .sdout_oe(sdout_oe), .fsync_out(fsync_out),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .underrun(underrun)
  );

  always @(negedge clk)
    if (rx_valid) begin
      rx_pulses <= rx_pulses + 1;
      rx_last   <= rx_data;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one input-clock cycle; outputs sampled late in the high half
  task automatic in_cycle(input logic fr, input logic ff, input logic d,
                          output logic sd, output logic fo, output logic oe);
    sclk_in = 1'b1; fsync_in = fr; sdin = d;
    repeat (HP) @(negedge clk);
    sd = sdout; fo = fsync_out; oe = sdout_oe;
    sclk_in = 1'b0; fsync_in = ff;
    repeat (HP) @(negedge clk);
  endtask

  task automatic load_tx(input logic [15:0] w);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7 ready before load", 32'(tx_ready), 1);
    tx_data = w; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R7 ready after load", 32'(tx_ready), 0);
  endtask

  task automatic do_frame(input logic wide, input logic lng, input logic dbl,
                          input logic fs_ok, input logic [15:0] rxw,
                          output logic [15:0] txcap, output logic [15:0] fsm,
                          output logic [15:0] oem, output int pulses);
    int n;
    int p0;
    logic sd, fo, oe;
    n = wide ? 16 : 8;
    p0 = rx_pulses;
    txcap = '0; fsm = '0; oem = '0;
    cfg_wide = wide; cfg_long = lng; cfg_dbl = dbl;
    in_cycle(1'b0, 1'b0, 1'b0, sd, fo, oe);
    in_cycle(1'b1, fs_ok, 1'b0, sd, fo, oe);
    for (int k = 0; k < n; k++) begin
      in_cycle(1'b0, 1'b0, rxw[n-1-k], sd, fo, oe);
      txcap[n-1-k] = sd; fsm[n-1-k] = fo; oem[n-1-k] = oe;
      if (dbl) in_cycle(1'b0, 1'b0, rxw[n-1-k], sd, fo, oe);
    end
    in_cycle(1'b0, 1'b0, 1'b0, sd, fo, oe);
    chk(!oe && !fo && !sd, "R5 idle after slot", {29'd0, oe, fo, sd}, 0);
    pulses = rx_pulses - p0;
  endtask

  task automatic t_reset();
    chk(tx_ready == 1'b1, "R7 reset ready", 32'(tx_ready), 1);
    chk(!sdout_oe && !sdout && !fsync_out, "R5 reset outputs",
        {29'd0, sdout_oe, sdout, fsync_out}, 0);
    chk(!underrun && rx_pulses == 0, "R8 reset underrun", 32'(underrun), 0);
  endtask

  task automatic t_frame(input logic wide, input logic lng, input logic dbl,
                         input logic [15:0] txw, input logic [15:0] rxw);
    logic [15:0] txcap, fsm, oem, mask, fexp;
    int pulses;
    string tag;
    tag  = dbl ? "R4 double-rate tx" : "R1 tx word";
    mask = wide ? 16'hFFFF : 16'h00FF;
    fexp = lng ? mask : (wide ? 16'h8000 : 16'h0080);
    load_tx(txw);
    do_frame(wide, lng, dbl, 1'b1, rxw, txcap, fsm, oem, pulses);
    chk(txcap == (txw & mask), tag, txcap, txw & mask);
    chk(pulses == 1, "R2 one rx strobe", pulses, 1);
    chk(rx_last == (rxw & mask), dbl ? "R4 double-rate rx" : "R2 rx word",
        rx_last, rxw & mask);
    chk(oem == mask, "R5 oe over slot", oem, mask);
    chk(fsm == fexp, "R6 fsync_out width", fsm, fexp);
    chk(underrun == 1'b0, "R8 no underrun", 32'(underrun), 0);
  endtask

  task automatic t_runt();
    logic [15:0] txcap, fsm, oem;
    int pulses;
    load_tx(16'h9D6B);
    do_frame(1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, txcap, fsm, oem, pulses);
    chk(pulses == 0, "R3 runt no rx", pulses, 0);
    chk(oem == 16'h0000, "R3 runt no drive", oem, 0);
    chk(tx_ready == 1'b0, "R3 runt keeps word", 32'(tx_ready), 0);
    do_frame(1'b1, 1'b0, 1'b0, 1'b1, 16'h0F0F, txcap, fsm, oem, pulses);
    chk(txcap == 16'h9D6B, "R3 held word sent next frame", txcap, 16'h9D6B);
    chk(tx_ready == 1'b1, "R7 ready after frame start", 32'(tx_ready), 1);
  endtask

  task automatic t_underrun();
    logic [15:0] txcap, fsm, oem;
    int pulses;
    do_frame(1'b0, 1'b1, 1'b0, 1'b1, 16'h0081, txcap, fsm, oem, pulses);
    chk(txcap == 16'h0000, "R8 zeros on underrun", txcap, 0);
    chk(underrun == 1'b1, "R8 underrun set", 32'(underrun), 1);
    chk(rx_last == 16'h0081 && pulses == 1, "R2 rx during underrun", rx_last, 16'h0081);
    load_tx(16'h00AA);
    repeat (5) @(negedge clk);
    chk(underrun == 1'b1, "R8 underrun sticky", 32'(underrun), 1);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_frame(1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C);
    t_frame(1'b1, 1'b1, 1'b0, 16'hBEEF, 16'h1234);
    t_frame(1'b1, 1'b0, 1'b1, 16'hC3A5, 16'h5A0F);
    t_frame(1'b0, 1'b1, 1'b1, 16'h0069, 16'h00D2);
    t_runt();
    t_underrun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule